// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block turns a virtual address into a physical address by looking the virtual page number up in a small table. Every entry's tag is compared in parallel. The page offset (13 bits for 8 KB pages) is passed straight through. Each entry carries a valid bit, a dirty bit, a two-bit permission code and the physical page number. A lookup is answered one clock after it is accepted. The answer is a hit, a miss, or a permission fault. On a hit it also carries the physical address. On a miss, an external page-table walker installs the translation through the fill port.

On a fill, the block picks the entry to overwrite. If the page is already present, its own entry is reused. Otherwise the lowest invalid entry is used. Otherwise an entry is drawn from a free-running LFSR and moved one step on if it equals the entry used most recently. A write that hits and is permitted marks its entry dirty. A flush input empties the whole table in one cycle.

Both the lookup port and the fill port are valid/ready. A lookup is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high. A fill is taken when `fill_valid_i` and `fill_ready_o` are both high. A fill has priority: `req_ready_o` is low while `fill_valid_i` or `flush_i` is high. `fill_ready_o` is low while `flush_i` is high. A requester must hold its request stable until it is taken. The response is a one-cycle pulse with no back-pressure, so the consumer must always accept it.

Top module: `tlb_fa`

## Requirements
- R1: After reset every entry is invalid. `rsp_valid_o` is low, `req_ready_o` is high, and the first lookup misses with no fault.
- R2: A lookup accepted on edge N gives `rsp_valid_o` high after edge N for exactly one cycle. On a hit, `rsp_paddr_o` is {physical page number, unchanged 13-bit offset}.
- R3: A lookup whose page matches no valid entry returns `rsp_hit_o`=0, `rsp_fault_o`=0 and `rsp_paddr_o`=0.
- R4: The permission codes are 0 read-only, 1 read/write, 2 execute-only, 3 no access. The access kinds are 0 read, 1 write, 2 execute; kind 3 is never allowed. A matching lookup whose kind the code does not allow returns `rsp_fault_o`=1 with `rsp_hit_o`=0 and `rsp_paddr_o`=0. Hit and fault are never high together.
- R5: `rsp_dirty_o` reports the entry's dirty bit after the access. A permitted write hit sets that bit, and it stays set. A faulting write leaves it unchanged. A miss reports 0.
- R6: While any entry is invalid, a fill of a new page evicts no valid entry. The table holds up to ENTRIES distinct pages, all of which hit.
- R7: With the table full, a fill of a new page evicts exactly one entry. That entry is never the one most recently hit or filled.
- R8: A fill of a page already present overwrites that entry. Later lookups return the new frame, and no other entry is lost.
- R9: A flush empties the table in one cycle. Every page present before the flush misses afterwards.
- R10: While `fill_valid_i` is high, `req_ready_o` is low and no response follows. While `flush_i` is high, `fill_ready_o` and `req_ready_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Invalidate every entry |
| req_valid_i | input | 1 | Lookup request valid |
| req_ready_o | output | 1 | Lookup can be accepted |
| req_vaddr_i | input | VPN_W+OFF_W (43) | Virtual address |
| req_kind_i | input | 2 | Access kind (0 read, 1 write, 2 execute) |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_hit_o | output | 1 | Permitted hit |
| rsp_fault_o | output | 1 | Permission violation on a matching entry |
| rsp_dirty_o | output | 1 | Entry dirty bit after the access |
| rsp_paddr_o | output | PPN_W+OFF_W (34) | Physical address on a hit, else 0 |
| fill_valid_i | input | 1 | Fill request valid |
| fill_ready_o | output | 1 | Fill can be accepted |
| fill_vpn_i | input | VPN_W (30) | Page to install |
| fill_ppn_i | input | PPN_W (21) | Frame for the page |
| fill_perm_i | input | 2 | Permission code of the new entry |
| fill_dirty_i | input | 1 | Initial dirty bit of the new entry |

## Verification
The assertions assume that a fill or lookup is never taken in the same cycle as a flush, and that a lookup never coincides with a fill. The ready outputs enforce both, and the bench only drives one operation per cycle anyway. They also assume ENTRIES is a power of two of at least two, so that the step past the last-used entry wraps inside the table; the bench keeps the default of 32. Because the random victim cannot be predicted, the bench keeps a model of which pages should be present. After each fill into a full table it counts misses, expecting exactly one lost page and never the page it just touched.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  localparam logic [1:0] PERM_RO   = 2'd0;
  localparam logic [1:0] PERM_RW   = 2'd1;
  localparam logic [1:0] PERM_XO   = 2'd2;

  typedef struct packed {
    logic       valid;
    logic       dirty;
    logic [1:0] perm;
  } tlb_meta_t;

  function automatic logic perm_ok(input logic [1:0] perm, input logic [1:0] kind);
    case (perm)
      PERM_RO: return kind == ACC_READ;
      PERM_RW: return (kind == ACC_READ) || (kind == ACC_WRITE);
      PERM_XO: return kind == ACC_EXEC;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 30,
  parameter int PPN_W   = 21,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               lk_en,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic [1:0]         lk_kind,
  output logic               lk_hit,
  output logic [IDX_W-1:0]   lk_idx,
  output logic [PPN_W-1:0]   lk_ppn,
  output logic               lk_allowed,
  output logic               lk_dirty,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [PPN_W-1:0]   fill_ppn,
  input  logic [1:0]         fill_perm,
  input  logic               fill_dirty,
  output logic               fl_hit,
  output logic [IDX_W-1:0]   fl_idx,
  output logic [ENTRIES-1:0] valid_vec
);
  logic [VPN_W-1:0]   tag_q  [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  tlb_meta_t          meta_q [ENTRIES];
  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] fl_match;

  // Two comparator banks: one for lookups, one for fill deduplication
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign valid_vec[g] = meta_q[g].valid;
    assign lk_match[g]  = meta_q[g].valid && (tag_q[g] == lk_vpn);
    assign fl_match[g]  = meta_q[g].valid && (tag_q[g] == fill_vpn);
  end

  always_comb begin
    lk_idx = '0;
    fl_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) lk_idx = IDX_W'(i);
      if (fl_match[i]) fl_idx = IDX_W'(i);
    end
  end

  assign lk_hit     = |lk_match;
  assign fl_hit     = |fl_match;
  assign lk_ppn     = ppn_q[lk_idx];
  assign lk_allowed = perm_ok(meta_q[lk_idx].perm, lk_kind);
  assign lk_dirty   = meta_q[lk_idx].dirty;

  logic wr_mark;
  assign wr_mark = lk_en && lk_hit && lk_allowed && (lk_kind == ACC_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) meta_q[i] <= '0;
    end else if (flush) begin
      for (int i = 0; i < ENTRIES; i++) meta_q[i].valid <= 1'b0;
    end else if (fill_en) begin
      meta_q[fill_idx] <= '{valid: 1'b1, dirty: fill_dirty, perm: fill_perm};
    end else if (wr_mark) begin
      meta_q[lk_idx].dirty <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !flush) begin
      tag_q[fill_idx] <= fill_vpn;
      ppn_q[fill_idx] <= fill_ppn;
    end
  end

  p_single_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));
  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec == '0));
  p_write_marks_dirty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mark && !flush && !fill_en) |=> meta_q[$past(lk_idx)].dirty);
  p_fill_installs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush) |=> valid_vec[$past(fill_idx)]);
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int          ENTRIES = 32,
  parameter logic [15:0] SEED    = 16'hACE1,
  localparam int         IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               touch_en,
  input  logic [IDX_W-1:0]   touch_idx,
  output logic [IDX_W-1:0]   victim_idx
);
  logic [15:0]      lfsr_q;
  logic [IDX_W-1:0] last_q;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] rnd_raw;
  logic [IDX_W-1:0] rnd_idx;
  logic             any_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= SEED;
      last_q <= '0;
    end else begin
      lfsr_q <= lfsr_q[0] ? ((lfsr_q >> 1) ^ 16'hB400) : (lfsr_q >> 1);
      if (touch_en) last_q <= touch_idx;
    end
  end

  // Lowest invalid entry wins when one exists
  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) free_idx = IDX_W'(i);
    end
  end

  assign any_free   = ~&valid_vec;
  assign rnd_raw    = lfsr_q[IDX_W-1:0];
  assign rnd_idx    = (rnd_raw == last_q) ? rnd_raw + IDX_W'(1) : rnd_raw;
  assign victim_idx = any_free ? free_idx : rnd_idx;

  p_victim_spares_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (&valid_vec) |-> (victim_idx != last_q));
  p_victim_prefers_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(&valid_vec) |-> !valid_vec[victim_idx]);
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 30,
  parameter int PPN_W   = 21,
  parameter int OFF_W   = 13,
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic [1:0]       req_kind_i,
  output logic             rsp_valid_o,
  output logic             rsp_hit_o,
  output logic             rsp_fault_o,
  output logic             rsp_dirty_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  input  logic             fill_valid_i,
  output logic             fill_ready_o,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  logic [1:0]       fill_perm_i,
  input  logic             fill_dirty_i
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic               req_fire, fill_fire;
  logic               lk_hit, lk_allowed, lk_dirty, fl_hit;
  logic [IDX_W-1:0]   lk_idx, fl_idx, victim_idx, fill_idx;
  logic [PPN_W-1:0]   lk_ppn;
  logic [ENTRIES-1:0] valid_vec;
  logic [OFF_W-1:0]   lk_off;

  assign fill_ready_o = !flush_i;
  assign req_ready_o  = !flush_i && !fill_valid_i;
  assign fill_fire    = fill_valid_i && fill_ready_o;
  assign req_fire     = req_valid_i && req_ready_o;
  assign lk_off       = req_vaddr_i[OFF_W-1:0];
  assign fill_idx     = fl_hit ? fl_idx : victim_idx;

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_cam (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush_i),
    .lk_en      (req_fire),
    .lk_vpn     (req_vaddr_i[VA_W-1:OFF_W]),
    .lk_kind    (req_kind_i),
    .lk_hit     (lk_hit),
    .lk_idx     (lk_idx),
    .lk_ppn     (lk_ppn),
    .lk_allowed (lk_allowed),
    .lk_dirty   (lk_dirty),
    .fill_en    (fill_fire),
    .fill_idx   (fill_idx),
    .fill_vpn   (fill_vpn_i),
    .fill_ppn   (fill_ppn_i),
    .fill_perm  (fill_perm_i),
    .fill_dirty (fill_dirty_i),
    .fl_hit     (fl_hit),
    .fl_idx     (fl_idx),
    .valid_vec  (valid_vec)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_vec  (valid_vec),
    .touch_en   (fill_fire || (req_fire && lk_hit)),
    .touch_idx  (fill_fire ? fill_idx : lk_idx),
    .victim_idx (victim_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_dirty_o <= 1'b0;
      rsp_paddr_o <= '0;
    end else begin
      rsp_valid_o <= req_fire;
      rsp_hit_o   <= req_fire && lk_hit && lk_allowed;
      rsp_fault_o <= req_fire && lk_hit && !lk_allowed;
      rsp_dirty_o <= req_fire && lk_hit &&
                     (lk_dirty || (lk_allowed && req_kind_i == ACC_WRITE));
      rsp_paddr_o <= (req_fire && lk_hit && lk_allowed) ? {lk_ppn, lk_off} : '0;
    end
  end

  p_rsp_follows_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> rsp_valid_o);
  p_no_rsp_unasked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_fire |=> !rsp_valid_o);
  p_hit_fault_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit_o && rsp_fault_o));
  p_offset_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> (!rsp_hit_o || rsp_paddr_o[OFF_W-1:0] == $past(lk_off)));
  p_quiet_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid_o |-> (!rsp_hit_o && !rsp_fault_o));
endmodule

// File: tb/tb_tlb_fa.sv
`timescale 1ns/1ps
module tb_tlb_fa;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [42:0] req_vaddr_i = '0;
  logic [1:0]  req_kind_i = '0;
  logic        rsp_valid_o, rsp_hit_o, rsp_fault_o, rsp_dirty_o;
  logic [33:0] rsp_paddr_o;
  logic        fill_valid_i = 1'b0;
  logic        fill_ready_o;
  logic [29:0] fill_vpn_i = '0;
  logic [20:0] fill_ppn_i = '0;
  logic [1:0]  fill_perm_i = '0;
  logic        fill_dirty_i = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic        g_valid, g_hit, g_fault, g_dirty;
  logic [33:0] g_pa;

  logic [29:0] mvpn [32];
  logic [20:0] mppn [32];

  always #10 clk = ~clk;

  tlb_fa dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic lookup(input logic [29:0] vpn, input logic [12:0] off, input logic [1:0] kind);
    req_valid_i = 1'b1;
    req_vaddr_i = {vpn, off};
    req_kind_i  = kind;
    @(negedge clk);
    req_valid_i = 1'b0;
    g_valid = rsp_valid_o;
    g_hit   = rsp_hit_o;
    g_fault = rsp_fault_o;
    g_dirty = rsp_dirty_o;
    g_pa    = rsp_paddr_o;
  endtask

  task automatic fill(input logic [29:0] vpn, input logic [20:0] ppn, input logic [1:0] perm, input logic dirty);
    fill_valid_i = 1'b1;
    fill_vpn_i   = vpn;
    fill_ppn_i   = ppn;
    fill_perm_i  = perm;
    fill_dirty_i = dirty;
    @(negedge clk);
    fill_valid_i = 1'b0;
  endtask

  task automatic t_reset();
    chk(rsp_valid_o == 1'b0, "R1 rsp_valid after reset", 64'(rsp_valid_o), 0);
    chk(req_ready_o == 1'b1, "R1 req_ready after reset", 64'(req_ready_o), 1);
    lookup(30'h0, 13'h0, 2'd0);
    chk(g_valid && !g_hit && !g_fault, "R1 empty lookup misses", {g_valid, g_hit, g_fault}, 3'b100);
  endtask

  task automatic t_basic();
    fill(30'h12345, 21'h0ABCD, 2'd1, 1'b0);
    lookup(30'h12345, 13'h1F0F, 2'd0);
    chk(g_valid && g_hit, "R2 hit flags", {g_valid, g_hit}, 2'b11);
    chk(g_pa == {21'h0ABCD, 13'h1F0F}, "R2 physical address", g_pa, {21'h0ABCD, 13'h1F0F});
    @(negedge clk);
    chk(rsp_valid_o == 1'b0, "R2 response lasts one cycle", 64'(rsp_valid_o), 0);
    lookup(30'h12346, 13'h0001, 2'd0);
    chk(g_valid && !g_hit && !g_fault && g_pa == '0, "R3 miss", {g_hit, g_fault, g_pa}, 0);
  endtask

  task automatic t_rights();
    fill(30'h20, 21'h20, 2'd0, 1'b0);
    fill(30'h21, 21'h21, 2'd2, 1'b0);
    fill(30'h22, 21'h22, 2'd3, 1'b0);
    lookup(30'h20, 13'h5, 2'd0);
    chk(g_hit && !g_fault, "R4 read-only allows read", {g_hit, g_fault}, 2'b10);
    lookup(30'h20, 13'h5, 2'd1);
    chk(!g_hit && g_fault && g_pa == '0, "R4 read-only blocks write", {g_hit, g_fault, g_pa}, 36'h4_0000_0000);
    lookup(30'h21, 13'h5, 2'd2);
    chk(g_hit && !g_fault, "R4 execute-only allows execute", {g_hit, g_fault}, 2'b10);
    lookup(30'h21, 13'h5, 2'd0);
    chk(!g_hit && g_fault, "R4 execute-only blocks read", {g_hit, g_fault}, 2'b01);
    lookup(30'h22, 13'h5, 2'd0);
    chk(!g_hit && g_fault, "R4 no-access blocks read", {g_hit, g_fault}, 2'b01);
    lookup(30'h12345, 13'h5, 2'd2);
    chk(!g_hit && g_fault, "R4 read/write blocks execute", {g_hit, g_fault}, 2'b01);
  endtask

  task automatic t_dirty();
    fill(30'h30, 21'h30, 2'd1, 1'b0);
    lookup(30'h30, 13'h0, 2'd0);
    chk(g_hit && !g_dirty, "R5 clean on read", 64'(g_dirty), 0);
    lookup(30'h30, 13'h0, 2'd1);
    chk(g_hit && g_dirty, "R5 write hit sets dirty", 64'(g_dirty), 1);
    lookup(30'h30, 13'h0, 2'd0);
    chk(g_hit && g_dirty, "R5 dirty sticks", 64'(g_dirty), 1);
    lookup(30'h20, 13'h0, 2'd1);
    lookup(30'h20, 13'h0, 2'd0);
    chk(g_hit && !g_dirty, "R5 faulting write leaves clean", 64'(g_dirty), 0);
    lookup(30'h3FF, 13'h0, 2'd1);
    chk(!g_hit && !g_dirty, "R5 miss reports clean", 64'(g_dirty), 0);
  endtask

  task automatic t_handshake();
    fill_valid_i = 1'b1; fill_vpn_i = 30'h40; fill_ppn_i = 21'h40;
    fill_perm_i = 2'd1; fill_dirty_i = 1'b0;
    req_valid_i = 1'b1; req_vaddr_i = {30'h30, 13'h0}; req_kind_i = 2'd0;
    #1;
    chk(req_ready_o == 1'b0, "R10 fill blocks lookup", 64'(req_ready_o), 0);
    @(negedge clk);
    fill_valid_i = 1'b0; req_valid_i = 1'b0;
    chk(rsp_valid_o == 1'b0, "R10 blocked lookup gives no response", 64'(rsp_valid_o), 0);
    flush_i = 1'b1;
    #1;
    chk(!fill_ready_o && !req_ready_o, "R10 flush blocks both ports", {fill_ready_o, req_ready_o}, 0);
    @(negedge clk);
    flush_i = 1'b0;
  endtask

  task automatic t_flush();
    int hits = 0;
    fill(30'h50, 21'h50, 2'd1, 1'b0);
    flush_i = 1'b1;
    @(negedge clk);
    flush_i = 1'b0;
    lookup(30'h50, 13'h0, 2'd0);       if (g_hit || g_fault) hits++;
    lookup(30'h12345, 13'h0, 2'd0);    if (g_hit || g_fault) hits++;
    lookup(30'h20, 13'h0, 2'd0);       if (g_hit || g_fault) hits++;
    chk(hits == 0, "R9 pages gone after flush", hits, 0);
  endtask

  task automatic t_capacity();
    int bad = 0;
    for (int i = 0; i < 32; i++) begin
      mvpn[i] = 30'h100 + 30'(i);
      mppn[i] = 21'h1000 + 21'(i);
      fill(mvpn[i], mppn[i], 2'd1, 1'b0);
    end
    for (int i = 0; i < 32; i++) begin
      lookup(mvpn[i], 13'h7, 2'd0);
      if (!g_hit || g_pa != {mppn[i], 13'h7}) bad++;
    end
    chk(bad == 0, "R6 all 32 pages resident", bad, 0);
  endtask

  task automatic t_overwrite();
    int bad = 0;
    mppn[5] = 21'h1AAAA;
    fill(mvpn[5], mppn[5], 2'd1, 1'b0);
    lookup(mvpn[5], 13'h3, 2'd0);
    chk(g_hit && g_pa == {mppn[5], 13'h3}, "R8 refill returns new frame", g_pa, {mppn[5], 13'h3});
    for (int i = 0; i < 32; i++) begin
      lookup(mvpn[i], 13'h0, 2'd0);
      if (!g_hit) bad++;
    end
    chk(bad == 0, "R8 refill loses no entry", bad, 0);
  endtask

  task automatic t_evict();
    for (int r = 0; r < 4; r++) begin
      int keep = (r * 9 + 3) % 32;
      int lost = 0;
      int lost_slot = -1;
      logic [29:0] nv = 30'h200 + 30'(r);
      logic [20:0] np = 21'h2000 + 21'(r);
      lookup(mvpn[keep], 13'h0, 2'd0);
      fill(nv, np, 2'd1, 1'b0);
      lookup(mvpn[keep], 13'h0, 2'd0);
      chk(g_hit, "R7 last-used entry survives", 64'(g_hit), 1);
      lookup(nv, 13'h9, 2'd0);
      chk(g_hit && g_pa == {np, 13'h9}, "R7 new page resident", g_pa, {np, 13'h9});
      for (int i = 0; i < 32; i++) begin
        if (i != keep) begin
          lookup(mvpn[i], 13'h0, 2'd0);
          if (!g_hit) begin lost++; lost_slot = i; end
        end
      end
      chk(lost == 1, "R7 exactly one eviction", lost, 1);
      if (lost_slot >= 0) begin
        mvpn[lost_slot] = nv;
        mppn[lost_slot] = np;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_rights();
    t_dirty();
    t_handshake();
    t_flush();
    t_capacity();
    t_overwrite();
    t_evict();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired before the tests ended");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule